// File: doc/BRIEF.md
# Watchdog and Power-On Reset Supervisor

This block produces the active-low reset for a processor. It watches two digital
flags from external supply comparators: one says the supply is above the upper
threshold and the other says it is below the lower threshold. It also watches a
watchdog kick line driven by the processor. All three inputs are asynchronous,
and each passes through a two-flop synchronizer before it is used. The supply
judgement has hysteresis. Once the supply is judged good, reset is held low for
one period T and is then released. T is a parameter counted in clock cycles.

While reset is released, the processor must produce a falling edge on the kick
line at least once per T. The kick line is deglitched, and only a high-to-low
change of the filtered level counts as a kick. If no kick arrives in time, the
reset output becomes a square wave that is low for T and then high for T. This
pulse train continues until an accepted kick returns the block to normal
operation. A supply fault overrides every other state, and when the supply
recovers the whole power-on delay starts again. A kick line left floating is
pulled high, so it produces no edges and leads to timeouts.

Top module: `wdt_por_supervisor`

## Requirements
- R1: A kick is accepted only when the filtered kick level changes from high to low. The supervisor acts on it MIN_KICK_CYC+2 cycles after the first low sample. A static low level, a static high level or a low-to-high change never restarts the timeout.
- R2: While the supply is judged bad, reset_n_o is 0. A fault is reflected at the output three clock edges after it is sampled.
- R3: The supply judgement becomes good when supply_hi_i=1 and supply_lo_i=0. It becomes bad when supply_lo_i=1, and supply_lo_i wins when both flags are 1. When both flags are 0, the judgement keeps its previous value.
- R4: Once the supply is judged good, reset_n_o stays 0 for exactly PERIOD_CYC cycles and then goes to 1. Kicks that arrive during this delay have no effect on it.
- R5: While reset_n_o is released, a span of PERIOD_CYC cycles with no accepted kick drives reset_n_o to 0.
- R6: After a timeout, reset_n_o alternates between 0 for PERIOD_CYC cycles and 1 for PERIOD_CYC cycles, for as long as no kick is accepted.
- R7: An accepted kick during the pulse train sets reset_n_o to 1 on the next cycle and restarts a full timeout of PERIOD_CYC cycles.
- R8: A change of kick level that lasts fewer than MIN_KICK_CYC consecutive synchronized samples is rejected and produces no kick.
- R9: A supply fault during the pulse train or during normal running forces reset_n_o low. When the supply recovers, the full power-on delay of R4 runs again.
- R10: While rst_n is 0, and on the first cycle after it is released, reset_n_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Asynchronous active-low reset of the supervisor logic |
| supply_hi_i | input | 1 | Comparator flag: supply above upper threshold (asynchronous) |
| supply_lo_i | input | 1 | Comparator flag: supply below lower threshold (asynchronous) |
| kick_i | input | 1 | Watchdog kick from the processor, idle high, serviced on falling edge |
| reset_n_o | output | 1 | Active-low processor reset |

## Verification
Every internal fault in this block shows up on the single reset output. A timeout counter or state register that is wrong moves a reset edge away from its cycle, either within one period T of the fault or by the next edge of the square wave. A filter that accepts glitches, or that counts rising edges, keeps reset high where a train should have started, and that difference becomes visible T cycles later. A wrong hysteresis or override shows within three cycles of a supply flag change, because reset fails to drop or is released early. The bench therefore compares the output with a reference model on every clock, so any deviation is caught in the cycle where it first appears.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic [2:0] {
    ST_HOLD  = 3'd0,  // supply bad, reset asserted
    ST_POR   = 3'd1,  // power-on delay, reset asserted
    ST_RUN   = 3'd2,  // normal, reset released, timeout running
    ST_TLOW  = 3'd3,  // pulse train, low half
    ST_THIGH = 3'd4   // pulse train, high half
  } sup_state_e;
endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int               WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/sup_supply_judge.sv
module sup_supply_judge (
  input  logic clk,
  input  logic rst_n,
  input  logic above_hi_i,
  input  logic below_lo_i,
  output logic good_o
);
  logic good_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          good_q <= 1'b0;
    else if (below_lo_i) good_q <= 1'b0;
    else if (above_hi_i) good_q <= 1'b1;
  end

  assign good_o = good_q;

  AST_LO_FORCES_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    below_lo_i |=> !good_o); // R3
  AST_HI_SETS_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    (above_hi_i && !below_lo_i) |=> good_o); // R3
  AST_BAND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!above_hi_i && !below_lo_i) |=> $stable(good_o)); // R3
endmodule

// File: rtl/sup_kick_filter.sv
module sup_kick_filter #(
  parameter int MIN_LOW_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick_sync_i,
  output logic kick_evt_o
);
  localparam int            RW       = (MIN_LOW_CYC < 2) ? 1 : $clog2(MIN_LOW_CYC + 1);
  localparam logic [RW-1:0] RUN_LAST = RW'(MIN_LOW_CYC - 1);

  logic          filt_q;
  logic [RW-1:0] run_q;
  logic          evt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b1;
      run_q  <= '0;
      evt_q  <= 1'b0;
    end else if (kick_sync_i != filt_q) begin
      if (run_q == RUN_LAST) begin
        filt_q <= kick_sync_i;
        run_q  <= '0;
        evt_q  <= filt_q;  // only a high-to-low change is a kick
      end else begin
        run_q  <= run_q + 1'b1;
        evt_q  <= 1'b0;
      end
    end else begin
      run_q <= '0;
      evt_q <= 1'b0;
    end
  end

  assign kick_evt_o = evt_q;

  AST_EVT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    kick_evt_o |-> (!filt_q && $past(filt_q))); // R1
  AST_EVT_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(filt_q) |-> $past(!kick_sync_i)); // R8
  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_LAST); // R8
endmodule

// File: rtl/sup_fsm.sv
module sup_fsm
  import sup_pkg::*;
#(
  parameter int PERIOD_CYC = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic good_i,
  input  logic kick_evt_i,
  output logic reset_n_o
);
  localparam int            CW   = (PERIOD_CYC < 2) ? 1 : $clog2(PERIOD_CYC);
  localparam logic [CW-1:0] LAST = CW'(PERIOD_CYC - 1);

  sup_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          expire;

  assign expire = (cnt_q == LAST);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q + 1'b1;
    if (!good_i) begin
      state_d = ST_HOLD;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_HOLD: begin
          state_d = ST_POR;
          cnt_d   = '0;
        end
        ST_POR: begin
          if (expire) begin
            state_d = ST_RUN;
            cnt_d   = '0;
          end
        end
        ST_RUN, ST_TLOW, ST_THIGH: begin
          if (kick_evt_i) begin
            state_d = ST_RUN;
            cnt_d   = '0;
          end else if (expire) begin
            state_d = (state_q == ST_TLOW) ? ST_THIGH : ST_TLOW;
            cnt_d   = '0;
          end
        end
        default: begin
          state_d = ST_HOLD;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HOLD;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign reset_n_o = (state_q == ST_RUN) || (state_q == ST_THIGH);

  AST_FAULT_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !good_i |=> !reset_n_o); // R2
  AST_POR_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_POR && !expire) |=> !reset_n_o); // R4
  AST_POR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_POR && expire && good_i) |=> reset_n_o); // R4
  AST_RUN_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && expire && good_i && !kick_evt_i) |=> !reset_n_o); // R5
  AST_TRAIN_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TLOW && expire && good_i && !kick_evt_i) |=> reset_n_o); // R6
  AST_KICK_RECOVERS: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_TLOW || state_q == ST_THIGH) && good_i && kick_evt_i)
      |=> (reset_n_o && cnt_q == '0)); // R7
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R5
endmodule

// File: rtl/wdt_por_supervisor.sv
module wdt_por_supervisor #(
  parameter int PERIOD_CYC   = 2000000,
  parameter int MIN_KICK_CYC = 1250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_hi_i,
  input  logic supply_lo_i,
  input  logic kick_i,
  output logic reset_n_o
);
  logic [2:0] raw_in;
  logic [2:0] sync_in;
  logic       good;
  logic       kick_evt;

  assign raw_in = {kick_i, supply_lo_i, supply_hi_i};

  sup_sync #(.WIDTH(3), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_in),
    .q_o   (sync_in)
  );

  sup_supply_judge u_judge (
    .clk        (clk),
    .rst_n      (rst_n),
    .above_hi_i (sync_in[0]),
    .below_lo_i (sync_in[1]),
    .good_o     (good)
  );

  sup_kick_filter #(.MIN_LOW_CYC(MIN_KICK_CYC)) u_filt (
    .clk         (clk),
    .rst_n       (rst_n),
    .kick_sync_i (sync_in[2]),
    .kick_evt_o  (kick_evt)
  );

  sup_fsm #(.PERIOD_CYC(PERIOD_CYC)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .good_i     (good),
    .kick_evt_i (kick_evt),
    .reset_n_o  (reset_n_o)
  );

  AST_RESET_LOW_AT_RELEASE: assert property (@(posedge clk)
    $rose(rst_n) |-> !reset_n_o); // R10
endmodule

// File: tb/tb_wdt_por_supervisor.sv
`timescale 1ns/1ps
module tb_wdt_por_supervisor;
  localparam int T = 40;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hi = 1'b0;
  logic lo = 1'b1;
  logic kick = 1'b1;
  logic reset_n;

  int checks = 0;
  int fails = 0;
  string phase = "R10";
  bit done = 1'b0;

  always #2 clk = ~clk;

  wdt_por_supervisor #(.PERIOD_CYC(T), .MIN_KICK_CYC(N)) dut (
    .clk (clk), .rst_n (rst_n), .supply_hi_i (hi), .supply_lo_i (lo),
    .kick_i (kick), .reset_n_o (reset_n)
  );

  // Reference model: delay queues, counters and a mode number.
  int m_kq[2] = '{1, 1};
  int m_hq[2] = '{0, 0};
  int m_lq[2] = '{0, 0};
  int m_filt = 1, m_run = 0, m_evt = 0, m_good = 0;
  int m_mode = 0;   // 0 fault,1 delay,2 normal,3 train low,4 train high
  int m_cnt = 0;
  int exp_rst = 0;

  always @(posedge clk) begin
    int n_mode, n_cnt, n_good, n_filt, n_run, n_evt, ks;
    if (!rst_n) begin
      m_kq = '{1, 1}; m_hq = '{0, 0}; m_lq = '{0, 0};
      m_filt = 1; m_run = 0; m_evt = 0; m_good = 0; m_mode = 0; m_cnt = 0;
    end else begin
      n_mode = m_mode; n_cnt = m_cnt + 1;
      if (!m_good) begin n_mode = 0; n_cnt = 0; end
      else if (m_mode == 0) begin n_mode = 1; n_cnt = 0; end
      else if (m_mode == 1) begin
        if (m_cnt == T - 1) begin n_mode = 2; n_cnt = 0; end
      end else if (m_evt) begin n_mode = 2; n_cnt = 0; end
      else if (m_cnt == T - 1) begin n_mode = (m_mode == 3) ? 4 : 3; n_cnt = 0; end
      n_good = m_lq[1] ? 0 : (m_hq[1] ? 1 : m_good);
      ks = m_kq[1]; n_filt = m_filt; n_run = 0; n_evt = 0;
      if (ks != m_filt) begin
        if (m_run + 1 >= N) begin n_filt = ks; n_evt = m_filt; end
        else n_run = m_run + 1;
      end
      m_mode = n_mode; m_cnt = n_cnt; m_good = n_good;
      m_filt = n_filt; m_run = n_run; m_evt = n_evt;
      m_kq[1] = m_kq[0]; m_kq[0] = kick;
      m_hq[1] = m_hq[0]; m_hq[0] = hi;
      m_lq[1] = m_lq[0]; m_lq[0] = lo;
    end
    exp_rst = (m_mode == 2 || m_mode == 4) ? 1 : 0;
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (reset_n !== exp_rst[0]) begin
        fails++;
        $display("FAIL %s: reset_n_o actual=%0b expected=%0b at %0t", phase, reset_n, exp_rst[0], $time);
      end
    end
  end

  task automatic chk(input string req, input logic act, input logic expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, expv, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input int low_len, input int high_len);
    kick = 1'b0; cyc(low_len);
    kick = 1'b1; cyc(high_len);
  endtask

  int rises;
  int lows;
  logic prev;

  initial begin
    fork
      begin
        cyc(20000);
        fails++;
        $display("FAIL watchdog: run hung");
      end
      begin
        cyc(3);
        chk("R10", reset_n, 1'b0);
        @(negedge clk) rst_n = 1'b1;
        chk("R10", reset_n, 1'b0);
        cyc(5);
        chk("R2", reset_n, 1'b0);

        // Power-on delay with kicks that must not shorten it
        phase = "R4";
        hi = 1'b1; lo = 1'b0;
        cyc(8); pulse(6, 10); pulse(6, 10);
        chk("R4", reset_n, 1'b0);
        cyc(30);
        chk("R4", reset_n, 1'b1);

        // Normal running inside the hysteresis band
        phase = "R3";
        hi = 1'b0;
        for (int i = 0; i < 8; i++) pulse(6, 14);
        chk("R3", reset_n, 1'b1);

        // Short glitches are not kicks
        phase = "R8";
        lows = 0;
        for (int i = 0; i < 10; i++) begin
          kick = 1'b0; cyc(2); kick = 1'b1;
          for (int j = 0; j < 13; j++) begin
            @(negedge clk); if (!reset_n) lows++;
          end
        end
        chk("R8", lows > 0, 1'b1);

        // A real kick ends the train
        phase = "R7";
        pulse(6, 10);
        chk("R7", reset_n, 1'b1);
        pulse(6, 14);

        // Static low after one edge, then a rising edge only
        phase = "R1";
        kick = 1'b0;
        rises = 0; prev = reset_n;
        for (int i = 0; i < 150; i++) begin
          @(negedge clk); if (reset_n && !prev) rises++; prev = reset_n;
        end
        chk("R1", rises > 0, 1'b1);
        kick = 1'b1;
        rises = 0;
        for (int i = 0; i < 150; i++) begin
          @(negedge clk); if (reset_n && !prev) rises++; prev = reset_n;
        end
        chk("R1", rises > 0, 1'b1);

        // Train with no kicks: square wave
        phase = "R6";
        rises = 0;
        for (int i = 0; i < 240; i++) begin
          @(negedge clk); if (reset_n && !prev) rises++; prev = reset_n;
        end
        chk("R6", rises >= 2, 1'b1);

        // Fault during the train, then recovery restarts the delay
        phase = "R9";
        lo = 1'b1; cyc(20);
        chk("R9", reset_n, 1'b0);
        lo = 1'b0; hi = 1'b1;
        cyc(T);
        chk("R9", reset_n, 1'b0);
        cyc(6);
        chk("R9", reset_n, 1'b1);

        // Normal running, timeout after kicks stop
        phase = "R5";
        pulse(6, 14); pulse(6, 14);
        cyc(T);
        chk("R5", reset_n, 1'b0);

        // Both flags set: low flag wins
        phase = "R3";
        pulse(6, 10);
        lo = 1'b1;
        cyc(6);
        chk("R3", reset_n, 1'b0);
        cyc(4);
        done = 1'b1;
      end
    join_any
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule